// File: doc/BRIEF.md
# Macro-op Issue Queue with Two-Stage Wakeup and Select

This block is the scheduling window of an out-of-order core. Each entry holds one macro-op, which is either two dependent micro-ops fused together or a single micro-op. A macro-op has at most two source operands and one destination name. Source readiness is tracked per entry, selection picks whole entries, and one destination tag is broadcast for each issued macro-op. The tag names a macro-op, not a physical register.

The front end writes at most one macro-op per cycle. It supplies the macro-op's destination tag, a sequence number, and for each source a valid bit, a tag and the ready status it saw. Every cycle, up to `ISSUE_W` ready entries are granted, oldest first. Each grant is reported on an issue lane as the entry index and the destination tag. That tag is also the wakeup broadcast for the next cycle. Because the broadcast is registered after select, a dependent macro-op issues two cycles after its producer. Results from units with longer latency come in on separate external wakeup lanes. A flush removes every entry younger than a given sequence number.

Each entry runs a small state machine with three states:

- `SLOT_FREE`: the entry is empty.
- `SLOT_WAIT`: at least one source is still pending.
- `SLOT_RDY`: all sources are ready and the entry can be selected.

The transitions are:

- **alloc-ready** (FREE to RDY): the entry is written and both sources are ready.
- **alloc-wait** (FREE to WAIT): the entry is written and a source is still pending.
- **wake** (WAIT to RDY): the last pending source sees its tag on a wakeup lane.
- **issue** (RDY to FREE): the entry is granted.
- **flush** (WAIT or RDY to FREE): the entry is younger than the flush point.

Top module: `mop_sched`

## Requirements
- R1: After reset, no entry is occupied, `q_full` is 0 and all `iss_valid` bits are 0.
- R2: A dispatch is written into the lowest-indexed free entry. `q_full` is 1 exactly when all `ENTRIES` entries are occupied. A dispatch made while the queue is full is dropped and never issues.
- R3: A source counts as ready at dispatch if it is not valid or if its ready bit is set. A macro-op whose sources are all ready at dispatch appears on an issue lane in the second cycle after the dispatch cycle.
- R4: A source whose tag is on any wakeup lane (internal or external) in the dispatch cycle is captured as ready.
- R5: A waiting entry becomes ready when its pending source tags appear on the issue lanes. A dependent macro-op issues two cycles after its producer and never earlier.
- R6: An external wakeup lane `k` carries its tag in `ext_wake_tag[k*TAG_W +: TAG_W]`. It wakes matching sources like an internal broadcast does, and a macro-op made ready this way issues in the second cycle after the wakeup.
- R7: At most `ISSUE_W` entries are granted per cycle. Lane 0 carries the oldest granted entry (in dispatch order), and lanes are filled from 0 upward with no gaps.
- R8: Each macro-op is granted exactly once. Its entry is free in the cycle after the grant, and no two lanes in a cycle carry the same index.
- R9: When `flush_valid` is high, every occupied entry whose sequence number `s` satisfies `0 < (s - flush_seq) mod 2^SEQ_W < 2^(SEQ_W-1)` is freed at the end of that cycle and is never granted. A dispatch in the same cycle is dropped.
- R10: Each grant carries the destination tag given at that macro-op's dispatch in `iss_tag[k*TAG_W +: TAG_W]`, with its entry index in `iss_idx[k*IDX_W +: IDX_W]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch a macro-op this cycle |
| disp_dst_tag | input | TAG_W | Macro-op name broadcast when issued |
| disp_seq | input | SEQ_W | Program-order sequence number |
| disp_src0_vld | input | 1 | First source exists |
| disp_src0_tag | input | TAG_W | First source producer tag |
| disp_src0_rdy | input | 1 | First source ready at dispatch |
| disp_src1_vld | input | 1 | Second source exists |
| disp_src1_tag | input | TAG_W | Second source producer tag |
| disp_src1_rdy | input | 1 | Second source ready at dispatch |
| ext_wake_vld | input | EXT_W | External wakeup lane valid bits |
| ext_wake_tag | input | EXT_W*TAG_W | External wakeup tags |
| flush_valid | input | 1 | Flush request |
| flush_seq | input | SEQ_W | Entries younger than this are removed |
| q_full | output | 1 | All entries occupied |
| iss_valid | output | ISSUE_W | Issue lane valid bits |
| iss_idx | output | ISSUE_W*IDX_W | Granted entry index per lane |
| iss_tag | output | ISSUE_W*TAG_W | Broadcast destination tag per lane |

## Verification
The hardest situation to reach from the ports is a dispatch whose source tag is broadcast in the very same cycle. The bench sets this up on purpose: it dispatches a consumer exactly in the cycle its producer appears on the lanes, and again in the cycle an external wakeup carries the tag. A second hard case is a completely full queue being woken all at once, so that age order decides the grants over several cycles. The bench fills all entries behind one pending tag before releasing it. Long random runs draw source tags from recently dispatched destinations to create dependence chains, and they mix in flushes at nearby sequence numbers, all compared against a cycle-accurate model in the bench.

// File: rtl/mopq_pkg.sv
package mopq_pkg;
    typedef enum logic [1:0] {
        SLOT_FREE = 2'd0,
        SLOT_WAIT = 2'd1,
        SLOT_RDY  = 2'd2
    } slot_state_e;
endpackage

// File: rtl/mopq_slot.sv
module mopq_slot
    import mopq_pkg::*;
#(
    parameter int TAG_W = 6,
    parameter int SEQ_W = 8,
    parameter int NWAKE = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               alloc,
    input  logic [TAG_W-1:0]   d_dst,
    input  logic [SEQ_W-1:0]   d_seq,
    input  logic [TAG_W-1:0]   d_t0,
    input  logic               d_r0,
    input  logic [TAG_W-1:0]   d_t1,
    input  logic               d_r1,
    input  logic [NWAKE-1:0]   wk_vld,
    input  logic [NWAKE*TAG_W-1:0] wk_tag,
    input  logic               grant,
    input  logic               flush_en,
    input  logic [SEQ_W-1:0]   flush_seq,
    output logic               is_free,
    output logic               is_rdy,
    output logic               is_killed,
    output logic [TAG_W-1:0]   dst_tag
);
    slot_state_e      st_q, st_d;
    logic             r0_q, r0_d, r1_q, r1_d;
    logic [TAG_W-1:0] t0_q, t0_d, t1_q, t1_d, dst_q, dst_d;
    logic [SEQ_W-1:0] seq_q, seq_d;
    logic             hit0, hit1;
    logic [SEQ_W-1:0] age_diff;

    // tag match against every wakeup lane
    always_comb begin
        hit0 = 1'b0;
        hit1 = 1'b0;
        for (int k = 0; k < NWAKE; k++) begin
            if (wk_vld[k] && wk_tag[k*TAG_W +: TAG_W] == t0_q) hit0 = 1'b1;
            if (wk_vld[k] && wk_tag[k*TAG_W +: TAG_W] == t1_q) hit1 = 1'b1;
        end
    end

    // wrap-aware younger-than test for flush
    assign age_diff  = seq_q - flush_seq;
    assign is_killed = flush_en && (st_q != SLOT_FREE) &&
                       (age_diff != '0) && !age_diff[SEQ_W-1];

    // next-state process
    always_comb begin
        st_d  = st_q;
        r0_d  = r0_q;
        r1_d  = r1_q;
        t0_d  = t0_q;
        t1_d  = t1_q;
        dst_d = dst_q;
        seq_d = seq_q;
        unique case (st_q)
            SLOT_FREE: begin
                if (alloc) begin
                    r0_d  = d_r0;
                    r1_d  = d_r1;
                    t0_d  = d_t0;
                    t1_d  = d_t1;
                    dst_d = d_dst;
                    seq_d = d_seq;
                    st_d  = (d_r0 && d_r1) ? SLOT_RDY : SLOT_WAIT;
                end
            end
            SLOT_WAIT: begin
                if (is_killed) begin
                    st_d = SLOT_FREE;
                end else begin
                    r0_d = r0_q | hit0;
                    r1_d = r1_q | hit1;
                    if (r0_d && r1_d) st_d = SLOT_RDY;
                end
            end
            SLOT_RDY: begin
                if (is_killed || grant) st_d = SLOT_FREE;
            end
            default: st_d = SLOT_FREE;
        endcase
    end

    // state register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= SLOT_FREE;
            r0_q  <= 1'b0;
            r1_q  <= 1'b0;
            t0_q  <= '0;
            t1_q  <= '0;
            dst_q <= '0;
            seq_q <= '0;
        end else begin
            st_q  <= st_d;
            r0_q  <= r0_d;
            r1_q  <= r1_d;
            t0_q  <= t0_d;
            t1_q  <= t1_d;
            dst_q <= dst_d;
            seq_q <= seq_d;
        end
    end

    assign is_free = (st_q == SLOT_FREE);
    assign is_rdy  = (st_q == SLOT_RDY);
    assign dst_tag = dst_q;

    // R2: allocation only targets an empty entry
    p_alloc_into_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> st_q == SLOT_FREE);
    // R8: select only grants entries that are ready
    p_grant_only_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> st_q == SLOT_RDY);
    // R8: a granted entry is released the next cycle
    p_grant_releases_r8: assert property (@(posedge clk) disable iff (!rst_n)
        grant |=> st_q == SLOT_FREE);
    // R9: a flushed entry is released the next cycle
    p_kill_releases_r9: assert property (@(posedge clk) disable iff (!rst_n)
        is_killed |=> st_q == SLOT_FREE);
    // R8: a ready entry waits until granted or flushed
    p_rdy_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SLOT_RDY && !grant && !is_killed) |=> st_q == SLOT_RDY);
endmodule

// File: rtl/mopq_age.sv
module mopq_age #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] alloc_vec,
    output logic [N-1:0] older_than [N]
);
    // m_q[j][i] set: entry j was written before entry i
    logic [N-1:0] m_q [N];
    logic         conflict;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < N; j++) m_q[j] <= '0;
        end else begin
            for (int j = 0; j < N; j++) begin
                for (int i = 0; i < N; i++) begin
                    if (alloc_vec[j])      m_q[j][i] <= 1'b0;
                    else if (alloc_vec[i]) m_q[j][i] <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        conflict = 1'b0;
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                older_than[i][j] = m_q[j][i];
                if (m_q[i][j] && m_q[j][i]) conflict = 1'b1;
            end
        end
    end

    // R2: at most one entry written per cycle
    p_alloc_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(alloc_vec));
    // R7: the age order never claims two entries older than each other
    p_age_antisym_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !conflict);
endmodule

// File: rtl/mopq_pick.sv
module mopq_pick #(
    parameter int N     = 16,
    parameter int W     = 3,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     cand,
    input  logic [N-1:0]     older_than [N],
    output logic [N-1:0]     grant,
    output logic [W-1:0]     slot_vld,
    output logic [W*IDX_W-1:0] slot_idx
);
    localparam logic [IDX_W:0] LANES = (IDX_W+1)'(W);

    logic [IDX_W:0] rank [N];

    // rank = number of ready candidates older than this entry
    always_comb begin
        for (int i = 0; i < N; i++) begin
            rank[i] = '0;
            for (int j = 0; j < N; j++) begin
                rank[i] = rank[i] + {{IDX_W{1'b0}}, cand[j] & older_than[i][j]};
            end
            grant[i] = cand[i] && (rank[i] < LANES);
        end
    end

    // lane k takes the candidate of rank k
    always_comb begin
        slot_vld = '0;
        slot_idx = '0;
        for (int k = 0; k < W; k++) begin
            for (int i = 0; i < N; i++) begin
                if (grant[i] && rank[i] == (IDX_W+1)'(k)) begin
                    slot_vld[k] = 1'b1;
                    slot_idx[k*IDX_W +: IDX_W] = slot_idx[k*IDX_W +: IDX_W] | IDX_W'(i);
                end
            end
        end
    end

    // R7: never more grants than lanes
    p_grant_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(grant) <= W);

    for (genvar k = 1; k < W; k++) begin : g_pack
        // R7: lanes fill from zero without gaps
        p_lanes_packed_r7: assert property (@(posedge clk) disable iff (!rst_n)
            slot_vld[k] |-> slot_vld[k-1]);
    end
endmodule

// File: rtl/mop_sched.sv
module mop_sched #(
    parameter int ENTRIES = 16,
    parameter int ISSUE_W = 3,
    parameter int EXT_W   = 2,
    parameter int TAG_W   = 6,
    parameter int SEQ_W   = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     disp_valid,
    input  logic [TAG_W-1:0]         disp_dst_tag,
    input  logic [SEQ_W-1:0]         disp_seq,
    input  logic                     disp_src0_vld,
    input  logic [TAG_W-1:0]         disp_src0_tag,
    input  logic                     disp_src0_rdy,
    input  logic                     disp_src1_vld,
    input  logic [TAG_W-1:0]         disp_src1_tag,
    input  logic                     disp_src1_rdy,
    input  logic [EXT_W-1:0]         ext_wake_vld,
    input  logic [EXT_W*TAG_W-1:0]   ext_wake_tag,
    input  logic                     flush_valid,
    input  logic [SEQ_W-1:0]         flush_seq,
    output logic                     q_full,
    output logic [ISSUE_W-1:0]       iss_valid,
    output logic [ISSUE_W*IDX_W-1:0] iss_idx,
    output logic [ISSUE_W*TAG_W-1:0] iss_tag
);
    localparam int NWAKE = ISSUE_W + EXT_W;

    logic [ISSUE_W-1:0]       iss_vld_q;
    logic [ISSUE_W*IDX_W-1:0] iss_idx_q;
    logic [ISSUE_W*TAG_W-1:0] iss_tag_q;

    logic [NWAKE-1:0]         wk_vld;
    logic [NWAKE*TAG_W-1:0]   wk_tag;
    logic                     cap0, cap1, d_r0, d_r1;
    logic [ENTRIES-1:0]       free_vec, rdy_vec, kill_vec, alloc_vec, grant_vec, cand;
    logic [TAG_W-1:0]         dst_arr [ENTRIES];
    logic [ENTRIES-1:0]       older_than [ENTRIES];
    logic [ISSUE_W-1:0]       slot_vld;
    logic [ISSUE_W*IDX_W-1:0] slot_idx;
    logic                     found;

    // wakeup bus: registered own broadcasts plus external lanes
    assign wk_vld = {ext_wake_vld, iss_vld_q};
    assign wk_tag = {ext_wake_tag, iss_tag_q};

    // same-cycle capture of broadcasts for the entry being written
    always_comb begin
        cap0 = 1'b0;
        cap1 = 1'b0;
        for (int k = 0; k < NWAKE; k++) begin
            if (wk_vld[k] && wk_tag[k*TAG_W +: TAG_W] == disp_src0_tag) cap0 = 1'b1;
            if (wk_vld[k] && wk_tag[k*TAG_W +: TAG_W] == disp_src1_tag) cap1 = 1'b1;
        end
    end
    assign d_r0 = !disp_src0_vld || disp_src0_rdy || cap0;
    assign d_r1 = !disp_src1_vld || disp_src1_rdy || cap1;

    // lowest free entry receives the dispatch
    always_comb begin
        alloc_vec = '0;
        found     = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (free_vec[i] && !found) begin
                alloc_vec[i] = disp_valid && !flush_valid;
                found        = 1'b1;
            end
        end
    end
    assign q_full = ~|free_vec;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        mopq_slot #(.TAG_W(TAG_W), .SEQ_W(SEQ_W), .NWAKE(NWAKE)) slot_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .alloc     (alloc_vec[g]),
            .d_dst     (disp_dst_tag),
            .d_seq     (disp_seq),
            .d_t0      (disp_src0_tag),
            .d_r0      (d_r0),
            .d_t1      (disp_src1_tag),
            .d_r1      (d_r1),
            .wk_vld    (wk_vld),
            .wk_tag    (wk_tag),
            .grant     (grant_vec[g]),
            .flush_en  (flush_valid),
            .flush_seq (flush_seq),
            .is_free   (free_vec[g]),
            .is_rdy    (rdy_vec[g]),
            .is_killed (kill_vec[g]),
            .dst_tag   (dst_arr[g])
        );
    end

    assign cand = rdy_vec & ~kill_vec;

    mopq_age #(.N(ENTRIES)) age_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_vec  (alloc_vec),
        .older_than (older_than)
    );

    mopq_pick #(.N(ENTRIES), .W(ISSUE_W), .IDX_W(IDX_W)) pick_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cand       (cand),
        .older_than (older_than),
        .grant      (grant_vec),
        .slot_vld   (slot_vld),
        .slot_idx   (slot_idx)
    );

    // issue register: second pipeline stage, doubles as broadcast
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iss_vld_q <= '0;
            iss_idx_q <= '0;
            iss_tag_q <= '0;
        end else begin
            iss_vld_q <= slot_vld;
            iss_idx_q <= slot_idx;
            for (int k = 0; k < ISSUE_W; k++) begin
                iss_tag_q[k*TAG_W +: TAG_W] <= dst_arr[slot_idx[k*IDX_W +: IDX_W]];
            end
        end
    end

    assign iss_valid = iss_vld_q;
    assign iss_idx   = iss_idx_q;
    assign iss_tag   = iss_tag_q;

    // R2: a full queue writes nothing
    p_full_no_alloc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        q_full |-> alloc_vec == '0);
    // R9: dispatch is dropped during a flush
    p_flush_no_alloc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |-> alloc_vec == '0);

    for (genvar a = 0; a < ISSUE_W; a++) begin : g_la
        for (genvar b = a + 1; b < ISSUE_W; b++) begin : g_lb
            // R8: lanes in one cycle name distinct entries
            p_distinct_lanes_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (iss_valid[a] && iss_valid[b]) |->
                iss_idx[a*IDX_W +: IDX_W] != iss_idx[b*IDX_W +: IDX_W]);
        end
    end
endmodule

// File: tb/mop_sched_tb_top.sv
`timescale 1ns/1ps
module mop_sched_tb_top;
    localparam int N = 16, W = 3, EXT_W = 2, TAG_W = 6, SEQ_W = 8, IDX_W = 4;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n;
    logic disp_valid, disp_src0_vld, disp_src0_rdy, disp_src1_vld, disp_src1_rdy;
    logic [TAG_W-1:0] disp_dst_tag, disp_src0_tag, disp_src1_tag;
    logic [SEQ_W-1:0] disp_seq, flush_seq;
    logic [EXT_W-1:0] ext_wake_vld;
    logic [EXT_W*TAG_W-1:0] ext_wake_tag;
    logic flush_valid, q_full;
    logic [W-1:0] iss_valid;
    logic [W*IDX_W-1:0] iss_idx;
    logic [W*TAG_W-1:0] iss_tag;

    mop_sched dut_i (.*);

    int n_tests = 0, n_fail = 0;
    bit finished = 0;

    // reference model state
    int m_st[N], m_r0[N], m_r1[N], m_t0[N], m_t1[N], m_dst[N], m_seq[N], m_age[N];
    int age_ctr = 0;
    int e_vld[W], e_idx[W], e_tag[W];

    task automatic chk(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit m_hit(int tag);
        for (int k = 0; k < W; k++) if (e_vld[k] != 0 && e_tag[k] == tag) return 1;
        for (int x = 0; x < EXT_W; x++)
            if (ext_wake_vld[x] && int'(ext_wake_tag[x*TAG_W +: TAG_W]) == tag) return 1;
        return 0;
    endfunction

    function automatic bit younger(int s, int f);
        int d = (s - f) & 255;
        return d != 0 && d < 128;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < N; i++) m_st[i] = 0;
        for (int k = 0; k < W; k++) begin e_vld[k] = 0; e_idx[k] = 0; e_tag[k] = 0; end
    endtask

    task automatic model_step();
        bit kil[N]; bit taken[N]; int pk; int al = -1;
        int nv[W], ni[W], nt[W];
        if (disp_valid && !flush_valid)
            for (int i = 0; i < N; i++) if (m_st[i] == 0 && al < 0) al = i;
        for (int i = 0; i < N; i++) begin
            kil[i] = flush_valid && m_st[i] != 0 && younger(m_seq[i], int'(flush_seq));
            taken[i] = 0;
        end
        for (int k = 0; k < W; k++) begin
            pk = -1;
            for (int i = 0; i < N; i++)
                if (m_st[i] == 2 && !kil[i] && !taken[i] && (pk < 0 || m_age[i] < m_age[pk])) pk = i;
            nv[k] = (pk >= 0); ni[k] = (pk >= 0) ? pk : 0; nt[k] = (pk >= 0) ? m_dst[pk] : 0;
            if (pk >= 0) taken[pk] = 1;
        end
        for (int i = 0; i < N; i++) begin
            if (m_st[i] != 0) begin
                if (kil[i] || taken[i]) m_st[i] = 0;
                else if (m_st[i] == 1) begin
                    if (m_hit(m_t0[i])) m_r0[i] = 1;
                    if (m_hit(m_t1[i])) m_r1[i] = 1;
                    if (m_r0[i] != 0 && m_r1[i] != 0) m_st[i] = 2;
                end
            end
        end
        if (al >= 0) begin
            m_t0[al] = disp_src0_tag; m_t1[al] = disp_src1_tag;
            m_r0[al] = (!disp_src0_vld || disp_src0_rdy || m_hit(disp_src0_tag)) ? 1 : 0;
            m_r1[al] = (!disp_src1_vld || disp_src1_rdy || m_hit(disp_src1_tag)) ? 1 : 0;
            m_dst[al] = disp_dst_tag; m_seq[al] = disp_seq; m_age[al] = age_ctr++;
            m_st[al] = (m_r0[al] != 0 && m_r1[al] != 0) ? 2 : 1;
        end
        for (int k = 0; k < W; k++) begin e_vld[k] = nv[k]; e_idx[k] = ni[k]; e_tag[k] = nt[k]; end
    endtask

    task automatic compare();
        int fm = 1;
        for (int i = 0; i < N; i++) if (m_st[i] == 0) fm = 0;
        chk("R2 q_full", int'(q_full), fm);
        for (int k = 0; k < W; k++) begin
            chk("R7 lane valid", int'(iss_valid[k]), e_vld[k]);
            if (e_vld[k] != 0 && iss_valid[k]) begin
                chk("R7 lane index", int'(iss_idx[k*IDX_W +: IDX_W]), e_idx[k]);
                chk("R10 lane tag", int'(iss_tag[k*TAG_W +: TAG_W]), e_tag[k]);
            end
        end
    endtask

    task automatic tick();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic idle();
        disp_valid = 0; disp_dst_tag = 0; disp_seq = 0;
        disp_src0_vld = 0; disp_src0_tag = 0; disp_src0_rdy = 0;
        disp_src1_vld = 0; disp_src1_tag = 0; disp_src1_rdy = 0;
        ext_wake_vld = 0; ext_wake_tag = 0; flush_valid = 0; flush_seq = 0;
    endtask

    task automatic disp(int dst, int seq, int v0, int t0, int r0, int v1, int t1, int r1);
        disp_valid = 1; disp_dst_tag = TAG_W'(dst); disp_seq = SEQ_W'(seq);
        disp_src0_vld = v0[0]; disp_src0_tag = TAG_W'(t0); disp_src0_rdy = r0[0];
        disp_src1_vld = v1[0]; disp_src1_tag = TAG_W'(t1); disp_src1_rdy = r1[0];
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        #(2_000_000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            summary();
            $finish;
        end
    end

    initial begin
        int seqc, tp[8], tpi;
        void'($urandom(32'h5eed_1234));
        idle();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        model_reset();
        @(negedge clk);
        chk("R1 q_full after reset", int'(q_full), 0);
        chk("R1 iss_valid after reset", int'(iss_valid), 0);

        // R3: ready macro-op issues two cycles after dispatch
        disp(10, 1, 0, 0, 0, 0, 0, 0); tick(); idle();
        chk("R3 no issue one cycle after dispatch", int'(iss_valid), 0);
        // dependent on tag 10, dispatched in A's select cycle
        disp(11, 2, 1, 10, 0, 0, 0, 0); tick(); idle();
        chk("R3 issue lane0 valid", int'(iss_valid[0]), 1);
        chk("R3 issue lane0 tag", int'(iss_tag[TAG_W-1:0]), 10);
        tick();
        chk("R5 dependent not early", int'(iss_valid), 0);
        tick();
        chk("R5 dependent issues two cycles after producer", int'(iss_valid[0]), 1);
        chk("R5 dependent tag", int'(iss_tag[TAG_W-1:0]), 11);

        // R4: capture of the internal broadcast visible this cycle
        disp(12, 3, 1, 11, 0, 0, 0, 0); tick(); idle();
        chk("R4 nothing in flight", int'(iss_valid), 0);
        tick();
        chk("R4 internal capture issues", int'(iss_tag[TAG_W-1:0]), 12);
        // R4: capture of an external wakeup in the dispatch cycle
        disp(13, 4, 1, 20, 0, 0, 0, 0); ext_wake_vld = 2'b10; ext_wake_tag[TAG_W +: TAG_W] = 20;
        tick(); idle(); tick();
        chk("R4 external capture valid", int'(iss_valid[0]), 1);
        chk("R4 external capture tag", int'(iss_tag[TAG_W-1:0]), 13);

        // R6: external wakeup after dispatch
        disp(14, 5, 0, 0, 0, 1, 30, 0); tick(); idle();
        for (int c = 0; c < 3; c++) begin
            tick();
            chk("R6 waits for external wakeup", int'(iss_valid), 0);
        end
        ext_wake_vld = 2'b01; ext_wake_tag[TAG_W-1:0] = 30; tick(); idle();
        chk("R6 one cycle after wakeup", int'(iss_valid), 0);
        tick();
        chk("R6 issues two cycles after wakeup", int'(iss_tag[TAG_W-1:0]), 14);

        // R2/R7: fill the queue, then release every entry at once
        for (int n = 0; n < N; n++) begin disp(40 + n, 10 + n, 1, 60, 0, 0, 0, 0); tick(); end
        idle();
        chk("R2 queue full", int'(q_full), 1);
        disp(63, 30, 0, 0, 0, 0, 0, 0); tick(); idle();
        chk("R2 still full after dropped dispatch", int'(q_full), 1);
        ext_wake_vld = 2'b01; ext_wake_tag[TAG_W-1:0] = 60; tick(); idle();
        for (int p = 0; p < 6; p++) begin
            tick();
            for (int k = 0; k < W; k++) begin
                if (3 * p + k < N) begin
                    chk("R7 oldest-first lane valid", int'(iss_valid[k]), 1);
                    chk("R7 oldest-first lane tag", int'(iss_tag[k*TAG_W +: TAG_W]), 40 + 3 * p + k);
                end else chk("R7 trailing lane empty", int'(iss_valid[k]), 0);
            end
        end
        tick();
        chk("R2 dropped dispatch never issues", int'(iss_valid), 0);
        chk("R8 all entries freed", int'(q_full), 0);

        // R9: flush removes younger entries and drops same-cycle dispatch
        for (int n = 0; n < 6; n++) begin disp(1 + n, 100 + n, 1, 50, 0, 0, 0, 0); tick(); end
        idle();
        disp(7, 106, 0, 0, 0, 0, 0, 0); flush_valid = 1; flush_seq = 102; tick(); idle();
        ext_wake_vld = 2'b01; ext_wake_tag[TAG_W-1:0] = 50; tick(); idle();
        tick();
        for (int k = 0; k < W; k++)
            chk("R9 older entries survive", int'(iss_tag[k*TAG_W +: TAG_W]), 1 + k);
        tick();
        chk("R9 younger entries gone", int'(iss_valid), 0);

        // random phase with dependence chains and flushes
        seqc = 120; tpi = 0;
        for (int i = 0; i < 8; i++) tp[i] = i;
        for (int c = 0; c < 4000; c++) begin
            idle();
            if ($urandom_range(0, 9) < 6) begin
                int t0 = ($urandom_range(0, 1) != 0) ? tp[$urandom_range(0, 7)] : int'($urandom_range(0, 63));
                int t1 = ($urandom_range(0, 1) != 0) ? tp[$urandom_range(0, 7)] : int'($urandom_range(0, 63));
                int dst = int'($urandom_range(0, 63));
                disp(dst, seqc, int'($urandom_range(0, 1)), t0, int'($urandom_range(0, 9) < 3),
                     int'($urandom_range(0, 1)), t1, int'($urandom_range(0, 9) < 3));
                tp[tpi] = dst; tpi = (tpi + 1) % 8; seqc++;
            end
            for (int x = 0; x < EXT_W; x++) begin
                ext_wake_vld[x] = ($urandom_range(0, 9) < 4);
                ext_wake_tag[x*TAG_W +: TAG_W] = TAG_W'($urandom_range(0, 63));
            end
            if ($urandom_range(0, 49) == 0) begin
                flush_valid = 1; flush_seq = SEQ_W'(seqc - int'($urandom_range(0, 8)));
            end
            tick();
        end
        idle();
        finished = 1;
        summary();
        $finish;
    end
endmodule